// File: doc/BRIEF.md
# Stack and Control-Flow Sequencer

This block carries out the multi-cycle control-transfer operations of an 8-bit processor with a 16-bit program counter: subroutine call, subroutine return, software break, return from interrupt and jump through a pointer. It owns the program counter and the 8-bit stack pointer. It drives one byte-wide synchronous memory port. Read data on that port arrives in the cycle after the address is presented.

An operation starts when `start` is high in a cycle where the block is idle. `op_sel` picks the operation and `status_in` supplies the current processor status byte. While the sequence runs the block steps through its bus cycles on its own. It ends with a one-cycle `done` pulse. After that, `pc`, `sp` and `status_out` hold the results. When a return from interrupt pulls a status byte that changes the interrupt-mask bit, the block raises a one-cycle pulse. The pulse tells the surrounding core whether interrupts became masked or became unmasked.

Top module: `flow_seq`

## Requirements
- R1: After reset, `pc` is 0x0200, `sp` is 0xFF, `status_out` is 0x00, and `busy`, `done` and `mem_we` are low.
- R2: `op_sel` codes are 0 call, 1 return, 2 break, 3 return from interrupt and 4 pointer jump. When idle, `start` with a code of 5 to 7 is ignored: no cycle is run, no write is made, and `pc` and `sp` do not change. While busy, `start` is ignored and the running operation completes unchanged.
- R3: The stack lives at 0x0100 plus `sp`. A push writes at the current `sp` and then decrements it. A pop first increments `sp` and then reads there. Both wrap within 8 bits.
- R4: A call started with `pc` = P takes 6 cycles. The new `pc` is the address formed by the low byte at P and the high byte at P+1. It pushes P+1, high byte first and then low byte, and leaves `sp` two lower.
- R5: A return takes 6 cycles and makes no writes. It pops the low byte and then the high byte of an address. The new `pc` is that address plus one, and `sp` ends two higher.
- R6: A break started with `pc` = P takes 7 cycles. It pushes P+1 high byte, then P+1 low byte, then the status byte with bits 5 and 4 set. It then sets status bit 2 (the interrupt mask). The new `pc` is read from 0xFFFE (low) and 0xFFFF (high). `sp` ends three lower.
- R7: A return from interrupt takes 6 cycles and makes no writes. It pops the status byte first, then the `pc` low byte, then the high byte, and does not increment the loaded `pc`. The new status takes every bit from the popped byte except bit 5, which reads 1, and bit 4, which keeps its value from `status_in`.
- R8: A pointer jump takes 6 cycles and leaves `sp` unchanged. It reads a pointer from P and P+1. The new `pc` takes its low byte from the pointer and its high byte from the pointer with only its low byte incremented, so a pointer at 0xnnFF takes its high byte from 0xnn00.
- R9: When a return from interrupt changes status bit 2 from 0 to 1, `irq_mask_set` is high for exactly one cycle. When it changes bit 2 from 1 to 0, `irq_mask_clr` is high for exactly one cycle. Neither pulse occurs for any other operation or when bit 2 is unchanged.
- R10: `done` is high for exactly one cycle per operation, in its last busy cycle, and `busy` is low in the following cycle.
- R11: `mem_we` is high only in push cycles: two per call, three per break, none otherwise. It is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_sel | input | 3 | Operation code, see R2 |
| status_in | input | 8 | Status byte at the start of the operation |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of an operation |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status_out | output | 8 | Status byte after the operation |
| irq_mask_set | output | 1 | One-cycle pulse: interrupt mask became set by a status pull |
| irq_mask_clr | output | 1 | One-cycle pulse: interrupt mask became clear by a status pull |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the address |

## Verification
Some rules hold on every cycle, and the assertions check those. Writes only ever land in the stack page, and each write lowers `sp` by one. There are no writes while idle, and registers hold steady while idle with no start. `done` falls inside the busy window and is followed by idle. The two mask pulses are single-cycle and never coincide. The bench scenarios cover what only end results can show. These are the push order and the bytes pushed, the return address plus one on return, the vector fetch of the break, the status merge and pulse direction on return from interrupt, the same-page wrap of the pointer jump, and stack-pointer wrap in both directions.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int STEP_W    = 3;
    localparam int IMASK_BIT = 2;
    localparam int BRK_BIT   = 4;
    localparam int ONE_BIT   = 5;

    localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;
    localparam logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFE;
    localparam logic [DATA_W-1:0] BRK_MASK   = DATA_W'(1) << BRK_BIT;
    localparam logic [DATA_W-1:0] ONE_MASK   = DATA_W'(1) << ONE_BIT;

    typedef enum logic [2:0] {
        OP_CALL = 3'd0,
        OP_RET  = 3'd1,
        OP_BRK  = 3'd2,
        OP_RTI  = 3'd3,
        OP_JIND = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        AS_PC, AS_STK, AS_STK_NEXT, AS_VEC_LO, AS_VEC_HI, AS_PTR, AS_PTR_WRAP
    } asrc_e;

    typedef enum logic [1:0] { WS_PCH, WS_PCL, WS_STAT } wsrc_e;

    typedef enum logic [1:0] { CP_NONE, CP_TLO, CP_THI, CP_STAT } cap_e;

    typedef struct packed {
        asrc_e asrc;
        logic  we;
        wsrc_e wsrc;
        logic  sp_dec;
        logic  sp_inc;
        logic  pc_inc;
        cap_e  cap;
        logic  set_mask;
        logic  load_pc;
        logic  last;
    } uop_t;

    function automatic logic op_valid(logic [2:0] code);
        return code <= 3'd4;
    endfunction

    // One entry per bus cycle; read data named by cap lands one cycle later.
    function automatic uop_t uop_lookup(op_e op, logic [STEP_W-1:0] st);
        uop_t u;
        u = '{asrc: AS_PC, we: 1'b0, wsrc: WS_PCH, sp_dec: 1'b0, sp_inc: 1'b0,
              pc_inc: 1'b0, cap: CP_NONE, set_mask: 1'b0, load_pc: 1'b0, last: 1'b0};
        case (op)
            OP_CALL: case (st)
                3'd0: begin u.pc_inc = 1'b1; u.cap = CP_TLO; end
                3'd1: u.asrc = AS_STK;
                3'd2: begin u.asrc = AS_STK; u.we = 1'b1; u.wsrc = WS_PCH; u.sp_dec = 1'b1; end
                3'd3: begin u.asrc = AS_STK; u.we = 1'b1; u.wsrc = WS_PCL; u.sp_dec = 1'b1; end
                3'd4: u.cap = CP_THI;
                default: begin u.load_pc = 1'b1; u.last = 1'b1; end
            endcase
            OP_RET: case (st)
                3'd0: ;
                3'd1: u.asrc = AS_STK;
                3'd2: begin u.asrc = AS_STK_NEXT; u.sp_inc = 1'b1; u.cap = CP_TLO; end
                3'd3: begin u.asrc = AS_STK_NEXT; u.sp_inc = 1'b1; u.cap = CP_THI; end
                3'd4: begin u.asrc = AS_STK; u.load_pc = 1'b1; end
                default: begin u.pc_inc = 1'b1; u.last = 1'b1; end
            endcase
            OP_BRK: case (st)
                3'd0: u.pc_inc = 1'b1;
                3'd1: begin u.asrc = AS_STK; u.we = 1'b1; u.wsrc = WS_PCH; u.sp_dec = 1'b1; end
                3'd2: begin u.asrc = AS_STK; u.we = 1'b1; u.wsrc = WS_PCL; u.sp_dec = 1'b1; end
                3'd3: begin
                    u.asrc = AS_STK; u.we = 1'b1; u.wsrc = WS_STAT; u.sp_dec = 1'b1;
                    u.set_mask = 1'b1;
                end
                3'd4: begin u.asrc = AS_VEC_LO; u.cap = CP_TLO; end
                3'd5: begin u.asrc = AS_VEC_HI; u.cap = CP_THI; end
                default: begin u.load_pc = 1'b1; u.last = 1'b1; end
            endcase
            OP_RTI: case (st)
                3'd0: ;
                3'd1: u.asrc = AS_STK;
                3'd2: begin u.asrc = AS_STK_NEXT; u.sp_inc = 1'b1; u.cap = CP_STAT; end
                3'd3: begin u.asrc = AS_STK_NEXT; u.sp_inc = 1'b1; u.cap = CP_TLO; end
                3'd4: begin u.asrc = AS_STK_NEXT; u.sp_inc = 1'b1; u.cap = CP_THI; end
                default: begin u.load_pc = 1'b1; u.last = 1'b1; end
            endcase
            OP_JIND: case (st)
                3'd0: begin u.pc_inc = 1'b1; u.cap = CP_TLO; end
                3'd1: u.cap = CP_THI;
                3'd2: ;
                3'd3: begin u.asrc = AS_PTR; u.cap = CP_TLO; end
                3'd4: begin u.asrc = AS_PTR_WRAP; u.cap = CP_THI; end
                default: begin u.load_pc = 1'b1; u.last = 1'b1; end
            endcase
            default: u.last = 1'b1;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/fs_uop_decode.sv
module fs_uop_decode
    import flow_seq_pkg::*;
(
    input  op_e               op,
    input  logic [STEP_W-1:0] step,
    output uop_t              uop
);
    assign uop = uop_lookup(op, step);
endmodule

// File: rtl/fs_addr_mux.sv
module fs_addr_mux
    import flow_seq_pkg::*;
(
    input  asrc_e             asrc,
    input  wsrc_e             wsrc,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] sp,
    input  logic [DATA_W-1:0] tlo,
    input  logic [DATA_W-1:0] thi,
    input  logic [DATA_W-1:0] stat,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] sp_next;
    logic [DATA_W-1:0] tlo_next;

    assign sp_next  = sp + DATA_W'(1);
    assign tlo_next = tlo + DATA_W'(1);

    always_comb begin
        case (asrc)
            AS_STK:      addr = {STACK_PAGE, sp};
            AS_STK_NEXT: addr = {STACK_PAGE, sp_next};
            AS_VEC_LO:   addr = VEC_ADDR;
            AS_VEC_HI:   addr = VEC_ADDR | ADDR_W'(1);
            AS_PTR:      addr = {thi, tlo};
            AS_PTR_WRAP: addr = {thi, tlo_next};
            default:     addr = pc;
        endcase
        case (wsrc)
            WS_PCH:  wdata = pc[ADDR_W-1:DATA_W];
            WS_PCL:  wdata = pc[DATA_W-1:0];
            default: wdata = stat | BRK_MASK | ONE_MASK;
        endcase
    end
endmodule

// File: rtl/fs_status_pull.sv
module fs_status_pull
    import flow_seq_pkg::*;
(
    input  logic [DATA_W-1:0] prior,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] merged,
    output logic              rose,
    output logic              fell
);
    always_comb begin
        merged = (raw & ~(BRK_MASK | ONE_MASK)) | (prior & BRK_MASK) | ONE_MASK;
        rose   = !prior[IMASK_BIT] &&  merged[IMASK_BIT];
        fell   =  prior[IMASK_BIT] && !merged[IMASK_BIT];
    end
endmodule

// File: rtl/flow_seq.sv
module flow_seq
    import flow_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h0200,
    parameter logic [DATA_W-1:0] RESET_SP = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] status_in,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] status_out,
    output logic              irq_mask_set,
    output logic              irq_mask_clr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              busy_q;
    op_e               op_q;
    logic [STEP_W-1:0] step_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] tlo_q;
    logic [DATA_W-1:0] thi_q;
    cap_e              cap_q;
    logic              mset_q;
    logic              mclr_q;

    uop_t              uop;
    asrc_e             asrc_eff;
    logic [DATA_W-1:0] pulled;
    logic              pull_rose;
    logic              pull_fell;

    fs_uop_decode u_decode (
        .op   (op_q),
        .step (step_q),
        .uop  (uop)
    );

    assign asrc_eff = busy_q ? uop.asrc : AS_PC;

    fs_addr_mux u_addr (
        .asrc  (asrc_eff),
        .wsrc  (uop.wsrc),
        .pc    (pc_q),
        .sp    (sp_q),
        .tlo   (tlo_q),
        .thi   (thi_q),
        .stat  (stat_q),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    fs_status_pull u_pull (
        .prior  (stat_q),
        .raw    (mem_rdata),
        .merged (pulled),
        .rose   (pull_rose),
        .fell   (pull_fell)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            op_q   <= OP_CALL;
            step_q <= '0;
            pc_q   <= RESET_PC;
            sp_q   <= RESET_SP;
            stat_q <= '0;
            tlo_q  <= '0;
            thi_q  <= '0;
            cap_q  <= CP_NONE;
            mset_q <= 1'b0;
            mclr_q <= 1'b0;
        end else begin
            mset_q <= 1'b0;
            mclr_q <= 1'b0;
            cap_q  <= busy_q ? uop.cap : CP_NONE;
            // Data addressed in the previous cycle lands here.
            case (cap_q)
                CP_TLO:  tlo_q <= mem_rdata;
                CP_THI:  thi_q <= mem_rdata;
                CP_STAT: begin
                    stat_q <= pulled;
                    mset_q <= pull_rose;
                    mclr_q <= pull_fell;
                end
                default: ;
            endcase
            if (busy_q) begin
                if (uop.sp_dec)      sp_q <= sp_q - DATA_W'(1);
                else if (uop.sp_inc) sp_q <= sp_q + DATA_W'(1);
                if (uop.pc_inc)       pc_q <= pc_q + ADDR_W'(1);
                else if (uop.load_pc) pc_q <= {mem_rdata, tlo_q};
                if (uop.set_mask) stat_q[IMASK_BIT] <= 1'b1;
                if (uop.last) busy_q <= 1'b0;
                else          step_q <= step_q + STEP_W'(1);
            end else if (start && op_valid(op_sel)) begin
                busy_q <= 1'b1;
                op_q   <= op_e'(op_sel);
                step_q <= '0;
                stat_q <= status_in;
            end
        end
    end

    assign busy         = busy_q;
    assign done         = busy_q && uop.last;
    assign mem_we       = busy_q && uop.we;
    assign pc           = pc_q;
    assign sp           = sp_q;
    assign status_out   = stat_q;
    assign irq_mask_set = mset_q;
    assign irq_mask_clr = mclr_q;
endmodule

// File: rtl/fs_checker.sv
module fs_checker
    import flow_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] sp,
    input logic              irq_mask_set,
    input logic              irq_mask_clr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we
);
    p_done_in_op_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_done_then_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_mask_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_mask_set, irq_mask_clr}));

    p_mask_pulse_short_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_mask_set || irq_mask_clr) |=> !(irq_mask_set || irq_mask_clr));

    p_write_in_stack_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE));

    p_push_lowers_sp_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp == $past(sp) - DATA_W'(1)));

    p_no_write_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_we);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(pc) && $stable(sp)));
endmodule

bind flow_seq fs_checker u_fs_checker (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .pc           (pc),
    .sp           (sp),
    .irq_mask_set (irq_mask_set),
    .irq_mask_clr (irq_mask_clr),
    .mem_addr     (mem_addr),
    .mem_we       (mem_we)
);

// File: tb/flow_seq_bench.sv
module flow_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [7:0]  status_in = 8'h00;
    logic        busy, done, irq_mask_set, irq_mask_clr, mem_we;
    logic [15:0] pc, mem_addr;
    logic [7:0]  sp, status_out, mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_seq u_flow_seq (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .status_in(status_in),
        .busy(busy), .done(done), .pc(pc), .sp(sp), .status_out(status_out),
        .irq_mask_set(irq_mask_set), .irq_mask_clr(irq_mask_clr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    // Synchronous memory, 4K bytes aliased over the 64K space.
    logic [7:0]  mem [0:4095];
    logic [15:0] wa [0:7];
    logic [7:0]  wd [0:7];
    int          wn = 0;

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            if (wn < 8) begin
                wa[wn] <= mem_addr;
                wd[wn] <= mem_wdata;
            end
            wn <= wn + 1;
        end
        mem_rdata <= mem[mem_addr[11:0]];
    end

    int checks = 0;
    int errors = 0;
    int n_cyc, n_done, n_set, n_clr;
    logic [15:0] pc_m;
    logic [7:0]  sp_m;
    logic [15:0] ra [0:255];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] a, input logic [7:0] v);
        mem[a[11:0]] <= v;
    endtask

    task automatic run(input logic [2:0] code, input logic [7:0] st, input bit poke);
        @(negedge clk);
        wn <= 0;
        start = 1'b1; op_sel = code; status_in = st;
        @(negedge clk);
        start = 1'b0;
        n_cyc = 0; n_done = 0; n_set = 0; n_clr = 0;
        while (busy && n_cyc < 40) begin
            n_cyc++;
            if (done) n_done++;
            if (irq_mask_set) n_set++;
            if (irq_mask_clr) n_clr++;
            if (poke && n_cyc == 2) begin start = 1'b1; op_sel = 3'd2; end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        if (irq_mask_set) n_set++;
        if (irq_mask_clr) n_clr++;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] <= 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc, 16'h0200);
        chk("R1 sp", sp, 8'hFF);
        chk("R1 status", status_out, 8'h00);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 we", mem_we, 0);
        pc_m = 16'h0200;
        sp_m = 8'hFF;

        // R2 unused codes ignored
        for (int c = 5; c < 8; c++) begin
            run(3'(c), 8'h00, 1'b0);
            chk("R2 no cycles", n_cyc, 0);
            chk("R2 pc kept", pc, pc_m);
            chk("R2 sp kept", sp, sp_m);
            chk("R2 no writes", wn, 0);
        end

        // R8 pointer jump sweep, including same-page wrap
        for (int k = 0; k < 20; k++) begin
            logic [7:0]  plo, phi;
            logic [15:0] tgt;
            phi = 8'h0A + 8'(k % 4);
            plo = (k == 0 || k == 7) ? 8'hFF : 8'(k * 11);
            tgt = 16'h0200 + 16'((k + 1) * 16'h0040);
            put(pc_m, plo);
            put(pc_m + 16'd1, phi);
            put({phi, plo}, tgt[7:0]);
            put({phi, plo + 8'd1}, tgt[15:8]);
            if (plo == 8'hFF) put({phi + 8'd1, 8'h00}, ~tgt[15:8]);
            run(3'd4, 8'h00, 1'b0);
            chk("R8 pc", pc, tgt);
            chk("R8 sp", sp, sp_m);
            chk("R8 cycles", n_cyc, 6);
            chk("R10 done once", n_done, 1);
            chk("R11 no writes", wn, 0);
            pc_m = tgt;
        end

        // R2 start while busy is ignored
        put(pc_m, 8'h40);
        put(pc_m + 16'd1, 8'h0C);
        put(16'h0C40, 8'h80);
        put(16'h0C41, 8'h07);
        run(3'd4, 8'h00, 1'b1);
        chk("R2 busy start pc", pc, 16'h0780);
        chk("R2 busy start cycles", n_cyc, 6);
        chk("R2 busy start writes", wn, 0);
        chk("R2 busy start sp", sp, sp_m);
        pc_m = 16'h0780;

        // R4 calls, walking sp through the 0x00 -> 0xFF wrap (R3)
        for (int i = 0; i < 140; i++) begin
            logic [15:0] tgt, ret;
            tgt = 16'h0200 + 16'((i * 53) % 3072);
            ret = pc_m + 16'd1;
            put(pc_m, tgt[7:0]);
            put(pc_m + 16'd1, tgt[15:8]);
            run(3'd0, 8'h00, 1'b0);
            chk("R4 cycles", n_cyc, 6);
            chk("R11 call writes", wn, 2);
            chk("R3 hi addr", wa[0], {8'h01, sp_m});
            chk("R4 hi byte", wd[0], ret[15:8]);
            chk("R3 lo addr", wa[1], {8'h01, sp_m - 8'd1});
            chk("R4 lo byte", wd[1], ret[7:0]);
            sp_m = sp_m - 8'd2;
            chk("R4 sp", sp, sp_m);
            chk("R4 pc", pc, tgt);
            chk("R10 done once", n_done, 1);
            ra[i] = ret;
            pc_m = tgt;
        end

        // R5 returns of the latest 40 calls, crossing the wrap again
        for (int k = 0; k < 40; k++) begin
            run(3'd1, 8'h00, 1'b0);
            sp_m = sp_m + 8'd2;
            chk("R5 pc", pc, ra[139 - k] + 16'd1);
            chk("R5 sp", sp, sp_m);
            chk("R5 cycles", n_cyc, 6);
            chk("R11 ret writes", wn, 0);
            pc_m = ra[139 - k] + 16'd1;
        end

        // R6 break sweep over status values
        for (int k = 0; k < 8; k++) begin
            logic [7:0]  st;
            logic [15:0] vec, ret;
            st  = 8'(k * 29) & 8'hFB;
            vec = 16'h0400 + 16'(k * 16'h0030);
            ret = pc_m + 16'd1;
            put(16'hFFFE, vec[7:0]);
            put(16'hFFFF, vec[15:8]);
            run(3'd2, st, 1'b0);
            chk("R6 cycles", n_cyc, 7);
            chk("R11 brk writes", wn, 3);
            chk("R6 push hi", {wa[0], wd[0]}, {8'h01, sp_m, ret[15:8]});
            chk("R6 push lo", {wa[1], wd[1]}, {8'h01, sp_m - 8'd1, ret[7:0]});
            chk("R6 push status", {wa[2], wd[2]}, {8'h01, sp_m - 8'd2, st | 8'h30});
            chk("R6 mask set", status_out, st | 8'h04);
            chk("R9 no pulse on brk", n_set + n_clr, 0);
            sp_m = sp_m - 8'd3;
            chk("R6 sp", sp, sp_m);
            chk("R6 pc", pc, vec);
            pc_m = vec;
        end

        // R7 / R9 return from interrupt sweep
        for (int k = 0; k < 16; k++) begin
            logic [7:0]  old, rd, exp_st;
            logic [15:0] tgt;
            old = ((k & 1) != 0 ? 8'h04 : 8'h00) | (8'(k * 17) & 8'hFB);
            rd  = ((k & 2) != 0 ? 8'h04 : 8'h00) | (8'(k * 45) & 8'hFB);
            tgt = 16'h0300 + 16'(k * 16'h0020);
            exp_st = (rd & 8'hCF) | 8'h20 | (old & 8'h10);
            put({8'h01, sp_m + 8'd1}, rd);
            put({8'h01, sp_m + 8'd2}, tgt[7:0]);
            put({8'h01, sp_m + 8'd3}, tgt[15:8]);
            run(3'd3, old, 1'b0);
            chk("R7 status", status_out, exp_st);
            chk("R7 pc", pc, tgt);
            sp_m = sp_m + 8'd3;
            chk("R7 sp", sp, sp_m);
            chk("R7 cycles", n_cyc, 6);
            chk("R11 rti writes", wn, 0);
            chk("R9 set pulse", n_set, (!old[2] && rd[2]) ? 1 : 0);
            chk("R9 clr pulse", n_clr, (old[2] && !rd[2]) ? 1 : 0);
            pc_m = tgt;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule